// File: doc/BRIEF.md
# Aggregated Watchdog Supervisor

This block guards a system made of several independent agents. Each agent must pulse its own check-in strobe again and again. A single hardware timeout counter watches all of them together. The counter is restarted only when every enabled agent has checked in since the previous restart. A check-in from one agent on its own never refreshes the timer. If the counter runs out first, the block raises a system reset request for a fixed number of cycles. It then opens a fresh window without any outside help.

Software can leave an agent out of supervision by clearing its bit in the enable mask. Such an agent counts as having checked in already. A status vector shows which enabled agents have not yet checked in during the current window. The window length is read from the timeout input each time the counter is loaded.

The sequencer has three states:
- LOAD: loads the counter and clears all pending bits.
- WATCH: counts down and records check-ins.
- FIRE: drives the reset pulse.

The transitions are named as follows:
- LOAD→WATCH (arm): always taken after one cycle.
- WATCH→WATCH (restart): taken when the set of check-ins is complete. It reloads the counter and clears all pending bits.
- WATCH→WATCH (tick): the set is incomplete and the counter is above zero, so the counter decrements.
- WATCH→FIRE (expire): the set is incomplete and the counter is at zero.
- FIRE→FIRE (hold): the pulse has cycles left to run.
- FIRE→LOAD (release): the last pulse cycle has ended.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `reset_req` is 0 and `missing` equals `enable_mask`. Reset puts the block in LOAD with no check-ins recorded.
- R2: Bit i of `missing` is 1 exactly when agent i is enabled and no check-in of agent i has been recorded in the current window. A `checkin[i]` strobe seen in WATCH clears that bit from the next cycle, unless the window restarts.
- R3: An agent whose `enable_mask` bit is 0 never shows as 1 in `missing`. It never holds back a restart.
- R4: The counter is loaded with `timeout` in LOAD. If the set stays incomplete, the block spends `timeout`+1 cycles in WATCH, and `reset_req` rises at the clock edge that ends the last of them. Counted from the LOAD cycle, this is the (`timeout`+2)th edge.
- R5: `reset_req` stays high for exactly `RST_LEN` cycles. One LOAD cycle follows, in which `missing` equals `enable_mask`. A new window then starts.
- R6: A restart happens in any WATCH cycle in which every enabled agent has either checked in earlier in the window or is strobing in that cycle. The counter then reloads and all pending bits clear at the next edge, with no reset. With `enable_mask` all zero, `reset_req` never rises.
- R7: If the set completes in the same WATCH cycle in which the counter is at zero, the restart wins and no reset pulse is produced.
- R8: Check-in strobes during FIRE or LOAD are ignored. The next window starts with every enabled agent pending.
- R9: `timeout` is sampled only when the counter is loaded. Changing it during a window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| checkin | input | N_CLIENTS | One check-in strobe per agent, active high |
| enable_mask | input | N_CLIENTS | 1 = agent is supervised |
| timeout | input | CNT_W | Window length, in cycles minus one |
| reset_req | output | 1 | System reset request pulse |
| missing | output | N_CLIENTS | Enabled agents not yet checked in this window |

## Verification
The bench goes after several corner cases, each with a distinct failure signature:
- Completion landing in the cycle where the counter reads zero. A design that checks expiry first would fire a spurious reset here.
- Check-ins during the pulse and the reload cycle. A design that records them would start the next window with agents already marked present and could mask a dead agent.
- Staggered check-ins, where no two agents strobe together. A design that restarts on any single kick would never fire when one agent is silent. A design that needs simultaneous strobes would fire while every agent is healthy.
- A timeout change in the middle of a window, to catch a counter that reads the input live.
- An all-disabled mask, which must never reset.
- Exact pulse length and fire latency, to catch off-by-one errors in the counter and the pulse counter.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_WATCH = 2'd1,
        ST_FIRE  = 2'd2
    } wdg_state_e;
endpackage

// File: rtl/wdg_checkin_tracker.sv
// Holds one pending/seen flag per agent and reports set completion.
module wdg_checkin_tracker #(
    parameter int N_CLIENTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 capture,
    input  logic [N_CLIENTS-1:0] checkin,
    input  logic [N_CLIENTS-1:0] enable_mask,
    output logic                 all_done,
    output logic [N_CLIENTS-1:0] missing
);
    logic [N_CLIENTS-1:0] seen_q;

    for (genvar i = 0; i < N_CLIENTS; i++) begin : g_client
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seen_q[i] <= 1'b0;
            end else if (clear) begin
                seen_q[i] <= 1'b0;
            end else if (capture && checkin[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
    end

    // Complete when every enabled agent is recorded or strobing now.
    always_comb begin
        all_done = &(seen_q | checkin | ~enable_mask);
        missing  = enable_mask & ~seen_q;
    end
endmodule

// File: rtl/wdg_window_counter.sv
// Down-counter for the supervision window.
module wdg_window_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wdg_seq_fsm.sv
// Sequencer: LOAD -> WATCH -> FIRE -> LOAD.
module wdg_seq_fsm
    import wdg_pkg::*;
#(
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic all_done,
    input  logic expired,
    output logic reset_req,
    output logic trk_clear,
    output logic trk_capture,
    output logic cnt_load,
    output logic cnt_dec
);
    localparam int PW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(RST_LEN - 1);

    wdg_state_e state_q, state_d;
    logic [PW-1:0] pulse_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Pulse length counter: preset outside FIRE, counts down inside it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pulse_q <= PULSE_LAST;
        else if (state_q == ST_FIRE) pulse_q <= pulse_q - 1'b1;
        else                        pulse_q <= PULSE_LAST;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = ST_WATCH;                       // arm
            ST_WATCH: begin
                if (all_done)     state_d = ST_WATCH;           // restart
                else if (expired) state_d = ST_FIRE;            // expire
                else              state_d = ST_WATCH;           // tick
            end
            ST_FIRE:  state_d = (pulse_q == '0) ? ST_LOAD : ST_FIRE; // release / hold
            default:  state_d = ST_LOAD;
        endcase
    end

    // Outputs
    always_comb begin
        reset_req   = 1'b0;
        trk_clear   = 1'b0;
        trk_capture = 1'b0;
        cnt_load    = 1'b0;
        cnt_dec     = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                cnt_load  = 1'b1;
                trk_clear = 1'b1;
            end
            ST_WATCH: begin
                if (all_done) begin
                    cnt_load  = 1'b1;
                    trk_clear = 1'b1;
                end else if (expired) begin
                    trk_clear = 1'b1;
                end else begin
                    cnt_dec     = 1'b1;
                    trk_capture = 1'b1;
                end
            end
            ST_FIRE: begin
                reset_req = 1'b1;
                trk_clear = 1'b1;
            end
            default: trk_clear = 1'b1;
        endcase
    end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
    parameter int N_CLIENTS = 4,
    parameter int CNT_W     = 16,
    parameter int RST_LEN   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] checkin,
    input  logic [N_CLIENTS-1:0] enable_mask,
    input  logic [CNT_W-1:0]     timeout,
    output logic                 reset_req,
    output logic [N_CLIENTS-1:0] missing
);
    logic all_done, expired;
    logic trk_clear, trk_capture, cnt_load, cnt_dec;

    wdg_checkin_tracker #(.N_CLIENTS(N_CLIENTS)) i_tracker (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (trk_clear),
        .capture     (trk_capture),
        .checkin     (checkin),
        .enable_mask (enable_mask),
        .all_done    (all_done),
        .missing     (missing)
    );

    wdg_window_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .dec      (cnt_dec),
        .load_val (timeout),
        .expired  (expired)
    );

    wdg_seq_fsm #(.RST_LEN(RST_LEN)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_done    (all_done),
        .expired     (expired),
        .reset_req   (reset_req),
        .trk_clear   (trk_clear),
        .trk_capture (trk_capture),
        .cnt_load    (cnt_load),
        .cnt_dec     (cnt_dec)
    );
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
    parameter int N_CLIENTS = 4,
    parameter int RST_LEN   = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CLIENTS-1:0] enable_mask,
    input logic                 reset_req,
    input logic [N_CLIENTS-1:0] missing
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_cnt <= 0;
        else if (reset_req) hi_cnt <= hi_cnt + 1;
        else                hi_cnt <= 0;
    end

    // R5: pulse ends after exactly RST_LEN high cycles
    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_req) |-> hi_cnt == RST_LEN);

    // R5: pulse never grows past RST_LEN
    p_pulse_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> hi_cnt < RST_LEN);

    // R5: a reload cycle follows every pulse
    p_reload_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_req) |=> !reset_req);

    // R4: a reset only fires while some enabled agent was still pending
    p_fire_needs_missing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(missing) != '0);

    // R6: an all-disabled mask can never cause a reset
    p_no_fire_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> $past(enable_mask) != '0);
endmodule

bind wdg_supervisor wdg_supervisor_chk #(
    .N_CLIENTS (N_CLIENTS),
    .RST_LEN   (RST_LEN)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_mask (enable_mask),
    .reset_req   (reset_req),
    .missing     (missing)
);

// File: tb/test_wdg_supervisor.sv
`timescale 1ns/1ps
module test_wdg_supervisor;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int RL = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0] checkin = '0;
    logic [N-1:0] enable_mask = '1;
    logic [W-1:0] timeout = 16'd5;
    logic reset_req;
    logic [N-1:0] missing;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wdg_supervisor #(.N_CLIENTS(N), .CNT_W(W), .RST_LEN(RL)) i_wdg_supervisor (
        .clk(clk), .rst_n(rst_n), .checkin(checkin), .enable_mask(enable_mask),
        .timeout(timeout), .reset_req(reset_req), .missing(missing)
    );

    // Behavioural reference model: 0 = load, 1 = watch, 2 = fire
    int m_state, m_cnt, m_pulse;
    logic [N-1:0] m_seen;

    always @(posedge clk or negedge rst_n) begin
        logic [N-1:0] nxt;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_pulse = 0; m_seen = '0;
        end else begin
            case (m_state)
                0: begin m_cnt = int'(timeout); m_seen = '0; m_state = 1; end
                1: begin
                    nxt = m_seen | checkin;
                    if ((nxt | ~enable_mask) == '1) begin
                        m_cnt = int'(timeout); m_seen = '0;
                    end else if (m_cnt == 0) begin
                        m_state = 2; m_pulse = RL - 1; m_seen = '0;
                    end else begin
                        m_cnt = m_cnt - 1; m_seen = nxt;
                    end
                end
                default: begin
                    m_seen = '0;
                    if (m_pulse == 0) m_state = 0;
                    else m_pulse = m_pulse - 1;
                end
            endcase
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison, sampled mid-way between edges
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk("R4", "reset_req vs model", int'(reset_req), (m_state == 2) ? 1 : 0);
            chk("R2", "missing vs model", int'(missing), int'(enable_mask & ~m_seen));
        end
    end

    task automatic do_reset(input logic [W-1:0] t, input logic [N-1:0] en);
        @(negedge clk);
        rst_n = 0; checkin = '0; timeout = t; enable_mask = en;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk); #5; n++;
        end while (!reset_req && n < 200);
    endtask

    task automatic count_high(output int h);
        h = 1;
        forever begin
            @(negedge clk); #5;
            if (reset_req) h++; else break;
        end
    endtask

    initial begin
        int n, h;
        // R1: reset state
        do_reset(16'd5, 4'b1111);
        #5;
        chk("R1", "reset_req after reset", int'(reset_req), 0);
        chk("R1", "missing after reset", int'(missing), 4'b1111);

        // R4: fire latency with no check-ins
        wait_rise(n);
        chk("R4", "cycles to reset", n, 7);
        // R5: pulse length and clean new window
        count_high(h);
        chk("R5", "pulse length", h, RL);
        chk("R5", "missing in reload", int'(missing), 4'b1111);
        wait_rise(n);
        chk("R4", "cycles to second reset", n, 7);
        count_high(h);

        // R2: one check-in clears only its own bit
        do_reset(16'd5, 4'b1111);
        @(negedge clk); checkin = 4'b0001;
        @(negedge clk); checkin = 4'b0000; #5;
        chk("R2", "missing after agent0 check-in", int'(missing), 4'b1110);

        // R6: staggered check-ins, one per cycle, keep the system alive
        h = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk); checkin = 4'(1 << (c % 4));
            #5; if (reset_req) h++;
        end
        @(negedge clk); checkin = '0;
        chk("R6", "reset cycles with staggered check-ins", h, 0);

        // One silent agent: must fire
        h = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk); checkin = 4'(1 << (c % 3));
            #5; if (reset_req) h++;
        end
        @(negedge clk); checkin = '0;
        chk("R6", "silent agent causes reset", (h > 0) ? 1 : 0, 1);

        // R3: disabled agents never pending, never block restart
        do_reset(16'd5, 4'b0101);
        h = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk); checkin = (c % 2 == 0) ? 4'b0001 : 4'b0100;
            #5; if (reset_req) h++;
            if (c == 10) chk("R3", "disabled bits in missing", int'(missing & 4'b1010), 0);
        end
        @(negedge clk); checkin = '0;
        chk("R3", "reset cycles with two disabled agents", h, 0);

        // R6: all agents disabled -> no reset ever
        do_reset(16'd2, 4'b0000);
        h = 0;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk); #5; if (reset_req) h++;
        end
        chk("R6", "reset cycles with mask all zero", h, 0);

        // R7: completion in the zero-count cycle wins
        do_reset(16'd2, 4'b1111);
        @(negedge clk); @(negedge clk); @(negedge clk);
        checkin = 4'b1111;
        @(negedge clk); checkin = '0; #5;
        chk("R7", "no reset on late completion", int'(reset_req), 0);
        chk("R7", "window restarted", int'(missing), 4'b1111);

        // R8: check-ins during pulse and reload are ignored
        do_reset(16'd1, 4'b1111);
        wait_rise(n);
        checkin = 4'b1111;
        h = 1;
        forever begin
            @(negedge clk); checkin = 4'b1111; #5;
            if (reset_req) h++; else break;
        end
        chk("R8", "missing in reload despite strobes", int'(missing), 4'b1111);
        @(negedge clk); checkin = '0; #5;
        chk("R8", "missing at window start", int'(missing), 4'b1111);
        count_high(h);
        wait_rise(n);
        count_high(h);

        // R9: timeout change mid-window has no effect on this window
        do_reset(16'd3, 4'b1111);
        @(negedge clk); #5; n = 1;
        timeout = 16'd20;
        do begin
            @(negedge clk); #5; n++;
        end while (!reset_req && n < 200);
        chk("R9", "window uses loaded timeout", n, 5);
        count_high(h);
        wait_rise(n);
        chk("R9", "next window uses new timeout", n, 22);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule